// File: doc/BRIEF.md
# Dual-Rail Undervoltage Qualifier

This block supervises two supply rails for a pair of power-switch channel sequencers. It receives digitized comparator flags: one flag per rail that is high while that rail sits above its low threshold, and one flag that is high while the higher of the two rails sits above the main lockout level. It filters these flags and tells each sequencer whether its supply is good. When an undervoltage is confirmed, it sends that sequencer a one-cycle request to clear its fault latch.

Undervoltage is handled in two tiers. A confirmed main lockout takes both channels down and clears both fault latches. Neither channel comes back until the main flag has stayed high for a long start delay. A confirmed low on a single rail takes down and clears only that rail's channel, and the channel is released again as soon as the rail recovers. The block also merges the two sequencers' fault latches into one active-low fault line.

All three timings are parameters counted in clock cycles. At a 50 MHz clock the defaults correspond to 12 µs for the main filter, 8 µs for the rail filter and 160 ms for the start delay. Reset is treated as a main lockout that is already in force.

Top module: `dual_rail_uv_qualifier`

## Requirements
- R1: After reset, and after any confirmed main lockout, `supply_good_o` stays 2'b00 until `main_ok_i` has been sampled high on START_DLY consecutive clock edges. Each bit then turns on at that edge if its rail is not in lockout.
- R2: If `main_ok_i` drops low for even one edge before the start delay completes, the delay count restarts from zero.
- R3: When `main_ok_i` is sampled low on MAIN_FILT consecutive edges, both bits of `supply_good_o` go low and both bits of `fault_clr_o` pulse high at that edge.
- R4: A low on `main_ok_i` that lasts fewer than MAIN_FILT edges has no effect on any output. A single high sample resets the main filter count.
- R5: When `rail_ok_i[n]` is sampled low on RAIL_FILT consecutive edges, `supply_good_o[n]` goes low and `fault_clr_o[n]` pulses at that edge. The other channel's outputs are not changed.
- R6: A low on `rail_ok_i[n]` that lasts fewer than RAIL_FILT edges has no effect. A single high sample resets that rail's filter count.
- R7: After a rail lockout, with the main delay already complete, `supply_good_o[n]` returns high at the first edge that samples `rail_ok_i[n]` high. No start delay is applied.
- R8: Each `fault_clr_o` pulse lasts exactly one cycle. A flag that stays low after its lockout has been confirmed produces no further pulse.
- R9: `fault_n_o` is 0 whenever either bit of `ch_fault_i` is 1, and 1 otherwise. It follows its inputs without a clock delay.
- R10: While reset is asserted, `supply_good_o` is 2'b00 and `fault_clr_o` is 2'b00. The lockout states held at reset produce no clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_ok_i | input | 1 | High while the higher rail is above the main lockout level |
| rail_ok_i | input | 2 | Bit n high while rail n is above its low threshold |
| ch_fault_i | input | 2 | Bit n is channel n's fault latch |
| supply_good_o | output | 2 | Bit n: channel n may run |
| fault_clr_o | output | 2 | One-cycle request to clear channel n's fault latch |
| fault_n_o | output | 1 | Combined fault, low while any latch is set |

## Verification
Every filter decision lands on the clock edge that takes the last required low sample. That edge changes `supply_good_o` and `fault_clr_o` together, and the pulse is gone one edge later. The end of the start delay and a rail's recovery each show at the edge that samples the final high value. `fault_n_o` settles within the same cycle. The bench changes inputs on falling edges and reads outputs on the falling edge that follows exactly the number of rising edges each result needs. It checks one edge early and at the due edge for every filter and for the start delay.

// File: rtl/dual_rail_uv_qualifier.sv
module dual_rail_uv_qualifier #(
  parameter int unsigned MAIN_FILT = 600,
  parameter int unsigned RAIL_FILT = 400,
  parameter int unsigned START_DLY = 8_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_ok_i,
  input  logic [1:0] rail_ok_i,
  input  logic [1:0] ch_fault_i,
  output logic [1:0] supply_good_o,
  output logic [1:0] fault_clr_o,
  output logic       fault_n_o
);

  localparam int MW = $clog2(MAIN_FILT + 1);
  localparam int RW = $clog2(RAIL_FILT + 1);
  localparam int SW = $clog2(START_DLY + 1);
  localparam logic [MW-1:0] MAIN_LAST  = MW'(MAIN_FILT - 1);
  localparam logic [RW-1:0] RAIL_LAST  = RW'(RAIL_FILT - 1);
  localparam logic [SW-1:0] START_LAST = SW'(START_DLY - 1);

  logic [MW-1:0] main_lo_cnt;
  logic          main_uv_q;
  logic [SW-1:0] start_cnt;
  logic          ready_q;
  logic [1:0]    rail_uv_q;
  logic [1:0]    rail_hit;
  logic [1:0]    clr_q;
  logic          main_hit;

  assign main_hit = !main_ok_i && !main_uv_q && (main_lo_cnt == MAIN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_lo_cnt <= '0;
      main_uv_q   <= 1'b1;
    end else begin
      if (main_ok_i || main_uv_q) main_lo_cnt <= '0;
      else                        main_lo_cnt <= main_lo_cnt + 1'b1;
      if (main_ok_i)     main_uv_q <= 1'b0;
      else if (main_hit) main_uv_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_cnt <= '0;
      ready_q   <= 1'b0;
    end else begin
      if (!main_ok_i || ready_q) start_cnt <= '0;
      else                       start_cnt <= start_cnt + 1'b1;
      if (main_hit)                                          ready_q <= 1'b0;
      else if (main_ok_i && !ready_q && start_cnt == START_LAST) ready_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_rail
    logic [RW-1:0] lo_cnt;

    assign rail_hit[g] = !rail_ok_i[g] && !rail_uv_q[g] && (lo_cnt == RAIL_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_cnt       <= '0;
        rail_uv_q[g] <= 1'b1;
      end else begin
        if (rail_ok_i[g] || rail_uv_q[g]) lo_cnt <= '0;
        else                              lo_cnt <= lo_cnt + 1'b1;
        if (rail_ok_i[g])     rail_uv_q[g] <= 1'b0;
        else if (rail_hit[g]) rail_uv_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= '0;
    else        clr_q <= rail_hit | {2{main_hit}};
  end

  assign supply_good_o = {2{ready_q}} & ~rail_uv_q;
  assign fault_clr_o   = clr_q;
  assign fault_n_o     = ~|ch_fault_i;

endmodule

// File: rtl/dual_rail_uv_qualifier_chk.sv
module dual_rail_uv_qualifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       main_ok_i,
  input logic [1:0] rail_ok_i,
  input logic [1:0] ch_fault_i,
  input logic [1:0] supply_good_o,
  input logic [1:0] fault_clr_o,
  input logic       fault_n_o
);

  a_r9_fault_merge: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ch_fault_i[0]) || $rose(ch_fault_i[1])) |-> !fault_n_o);

  a_r3_main_clears_both: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr_o[0] && $past(rail_ok_i[0])) |-> fault_clr_o[1]);

  for (genvar g = 0; g < 2; g++) begin : g_ch
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fault_clr_o[g] |=> !fault_clr_o[g]);

    a_r5_clear_drops_good: assert property (@(posedge clk) disable iff (!rst_n)
      fault_clr_o[g] |-> !supply_good_o[g]);

    a_r5_rail_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_clr_o[g] && $past(main_ok_i)) |-> !$past(rail_ok_i[g]));
  end

endmodule

bind dual_rail_uv_qualifier dual_rail_uv_qualifier_chk chk_i (.*);

// File: tb/dual_rail_uv_qualifier_tb_top.sv
module dual_rail_uv_qualifier_tb_top;

  localparam int MF = 6;
  localparam int RF = 4;
  localparam int SD = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_ok = 1'b1;
  logic [1:0] rail_ok = 2'b11;
  logic [1:0] flt = 2'b00;
  logic [1:0] good, clr;
  logic       fn;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  dual_rail_uv_qualifier #(.MAIN_FILT(MF), .RAIL_FILT(RF), .START_DLY(SD)) dut_i (
    .clk(clk), .rst_n(rst_n), .main_ok_i(main_ok), .rail_ok_i(rail_ok),
    .ch_fault_i(flt), .supply_good_o(good), .fault_clr_o(clr), .fault_n_o(fn));

  // {main, rail[1:0], fault[1:0], hold[4:0], good[1:0], clr[1:0], fault_n}
  localparam int NV = 21;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 2'b11, 2'b00, 5'd1,  2'b11, 2'b00, 1'b1},  // R9 idle
    {1'b1, 2'b11, 2'b01, 5'd1,  2'b11, 2'b00, 1'b0},  // R9
    {1'b1, 2'b11, 2'b10, 5'd1,  2'b11, 2'b00, 1'b0},  // R9
    {1'b1, 2'b11, 2'b11, 5'd1,  2'b11, 2'b00, 1'b0},  // R9
    {1'b1, 2'b11, 2'b00, 5'd1,  2'b11, 2'b00, 1'b1},  // R9
    {1'b1, 2'b10, 2'b00, 5'd3,  2'b11, 2'b00, 1'b1},  // R6 short dip
    {1'b1, 2'b11, 2'b00, 5'd1,  2'b11, 2'b00, 1'b1},  // R6 count reset
    {1'b1, 2'b10, 2'b00, 5'd3,  2'b11, 2'b00, 1'b1},  // R6 restarted
    {1'b1, 2'b10, 2'b00, 5'd1,  2'b10, 2'b01, 1'b1},  // R5 rail0 confirm
    {1'b1, 2'b10, 2'b00, 5'd1,  2'b10, 2'b00, 1'b1},  // R8
    {1'b1, 2'b10, 2'b00, 5'd5,  2'b10, 2'b00, 1'b1},  // R8 no repeat
    {1'b1, 2'b11, 2'b00, 5'd1,  2'b11, 2'b00, 1'b1},  // R7 immediate
    {1'b1, 2'b01, 2'b00, 5'd4,  2'b01, 2'b10, 1'b1},  // R5 rail1, ch0 kept
    {1'b1, 2'b11, 2'b00, 5'd1,  2'b11, 2'b00, 1'b1},  // R7
    {1'b0, 2'b11, 2'b00, 5'd5,  2'b11, 2'b00, 1'b1},  // R4 short
    {1'b1, 2'b11, 2'b00, 5'd1,  2'b11, 2'b00, 1'b1},  // R4 count reset
    {1'b0, 2'b11, 2'b00, 5'd5,  2'b11, 2'b00, 1'b1},  // R4 restarted
    {1'b0, 2'b11, 2'b00, 5'd1,  2'b00, 2'b11, 1'b1},  // R3 confirm
    {1'b0, 2'b11, 2'b00, 5'd1,  2'b00, 2'b00, 1'b1},  // R8
    {1'b1, 2'b11, 2'b00, 5'd19, 2'b00, 2'b00, 1'b1},  // R1 delay again
    {1'b1, 2'b11, 2'b00, 5'd1,  2'b11, 2'b00, 1'b1}   // R1 done
  };

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    check("R10 good in reset", {2'b0, good}, 4'h0);
    check("R10 clr in reset", {2'b0, clr}, 4'h0);
    check("R9 fault_n idle", {3'b0, fn}, 4'h1);
    rst_n = 1'b1;
    wait_n(SD - 1);
    check("R1 before delay", {2'b0, good}, 4'h0);
    wait_n(1);
    check("R1 after delay", {2'b0, good}, 4'h3);

    for (int i = 0; i < NV; i++) begin
      {main_ok, rail_ok, flt} = VEC[i][14:10];
      wait_n(int'(VEC[i][9:5]));
      check($sformatf("vec %0d good", i), {2'b0, good}, {2'b0, VEC[i][4:3]});
      check($sformatf("vec %0d clr", i), {2'b0, clr}, {2'b0, VEC[i][2:1]});
      check($sformatf("vec %0d fault_n", i), {3'b0, fn}, {3'b0, VEC[i][0]});
    end

    // R2: a short dip inside the start delay restarts it
    main_ok = 1'b0;
    wait_n(MF);
    check("R3 lockout", {clr, good}, 4'hC);
    main_ok = 1'b1;
    wait_n(10);
    main_ok = 1'b0;
    wait_n(2);
    check("R2 short dip no clr", {2'b0, clr}, 4'h0);
    main_ok = 1'b1;
    wait_n(SD - 1);
    check("R2 delay restarted", {2'b0, good}, 4'h0);
    wait_n(1);
    check("R2 delay complete", {2'b0, good}, 4'h3);

    // R10: rail low through reset gives no pulse
    rst_n = 1'b0;
    rail_ok = 2'b10;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(RF + 2);
    check("R10 no clr from reset lockout", {2'b0, clr}, 4'h0);
    wait_n(SD);
    check("R10 rail0 still held", {2'b0, good}, 4'h2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5000 * 20ns);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule